// File: doc/BRIEF.md
# PPS-Aligned PLL Sync Pulse Generator

This block produces a single SYNC edge for an external clock-distribution PLL, placed a known number of reference clock cycles after a rising edge of the pulse-per-second input. It runs entirely in the reference clock domain. Software arms it by holding a level trigger high. The block then waits for the next PPS rising edge and counts a fixed two-cycle latency plus a programmable 8-bit extra delay. After that it raises SYNC and, one cycle later, a done flag.

SYNC and done remain high for as long as the trigger stays high. Only one SYNC edge is made per trigger assertion, so later PPS edges change nothing. Dropping the trigger returns the block to idle, with both outputs low. Dropping it before SYNC has fired abandons the attempt.

Top module: `pps_sync_pulse_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `sync_out` and `done_out` low and returns the sequencer to idle, also in the middle of a sequence.
- R2: While `arm_in` is low, PPS rising edges never raise `sync_out` or `done_out`.
- R3: With `arm_in` held high and `extra_delay_in` = 0, `sync_out` rises in the cycle after the 2nd rising clock edge counted from the first edge that samples `pps_in` high. That is a latency of 2 cycles.
- R4: A non-zero `extra_delay_in` value D (unsigned, sampled when the PPS edge is detected) makes the latency 2 + D cycles. For example, D = 3 gives 5 cycles and D = 255 gives 257 cycles.
- R5: `done_out` rises exactly one cycle after `sync_out` rises. It is never high while `sync_out` is low. Both stay high for as long as `arm_in` stays high.
- R6: When `arm_in` is sampled low, `sync_out` and `done_out` are both low after that same clock edge.
- R7: Only one SYNC edge is made per trigger assertion. Further PPS rising edges while `arm_in` stays high leave `sync_out` and `done_out` high.
- R8: If `arm_in` drops after the PPS edge but before `sync_out` rises, no SYNC edge is produced.
- R9: A PPS level that is already high when the block is armed does not fire it. Only a low-to-high transition seen while armed starts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| arm_in | input | 1 | Level trigger; high arms the block and keeps the completion state |
| extra_delay_in | input | DELAY_W | Cycles added to the fixed 2-cycle latency |
| sync_out | output | 1 | SYNC to the PLL; rises once per arming |
| done_out | output | 1 | Completion flag, cleared when `arm_in` drops |

## Verification
The latency is measured for extra delays of 0, 1, 3, 7 and 255. Sampling one cycle before and one cycle at the expected edge pins the count exactly. This separates an off-by-one in the fixed latency from one in the programmable part. PPS edges are applied while the block is disarmed, as a level that is already high at arming, and as repeated edges after completion. These show that only a fresh transition seen while armed can fire the block, and that it fires only once. Removing the trigger mid-delay, and resetting while done is high, check that both kinds of abort leave the outputs low.

// File: rtl/pps_sync_pkg.sv
package pps_sync_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_PPS  = 3'd1,
        ST_DELAY     = 3'd2,
        ST_SYNC_HIGH = 3'd3,
        ST_DONE      = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sync;
        logic       done;
    } seq_ctl_t;

endpackage

// File: rtl/pps_sync_chain.sv
// Multi-flop synchronizer for the asynchronous PPS input.
module pps_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pps_rise_detect.sv
// Flags a low-to-high step of the synchronized level, one cycle wide.
module pps_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/pps_delay_cnt.sv
// Down counter: loaded with the extra delay and flags the last counted cycle.
module pps_delay_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == ONE);
endmodule

// File: rtl/pps_sync_pulse_gen.sv
// Arms on a level trigger, waits for a PPS rising edge, then raises SYNC
// after SYNC_STAGES + extra_delay_in cycles and reports completion.
module pps_sync_pulse_gen
    import pps_sync_pkg::*;
#(
    parameter int DELAY_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pps_in,
    input  logic               arm_in,
    input  logic [DELAY_W-1:0] extra_delay_in,
    output logic               sync_out,
    output logic               done_out
);
    localparam seq_ctl_t CTL_RESET = '{state: ST_IDLE, sync: 1'b0, done: 1'b0};

    logic pps_lvl;
    logic pps_rise;
    logic cnt_load;
    logic cnt_expire;

    seq_ctl_t ctl_d, ctl_q;

    pps_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pps_in),
        .dout (pps_lvl)
    );

    pps_rise_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (pps_lvl),
        .rise  (pps_rise)
    );

    pps_delay_cnt #(.W(DELAY_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (extra_delay_in),
        .expire   (cnt_expire)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (arm_in) ctl_d.state = ST_WAIT_PPS;
            end
            ST_WAIT_PPS: begin
                if (!arm_in) begin
                    ctl_d.state = ST_IDLE;
                end else if (pps_rise) begin
                    if (extra_delay_in == '0) begin
                        ctl_d.state = ST_SYNC_HIGH;
                    end else begin
                        ctl_d.state = ST_DELAY;
                        cnt_load    = 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (!arm_in)         ctl_d.state = ST_IDLE;
                else if (cnt_expire) ctl_d.state = ST_SYNC_HIGH;
            end
            ST_SYNC_HIGH: begin
                if (!arm_in) ctl_d.state = ST_IDLE;
                else         ctl_d.state = ST_DONE;
            end
            ST_DONE: begin
                if (!arm_in) ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        ctl_d.sync = (ctl_d.state == ST_SYNC_HIGH) || (ctl_d.state == ST_DONE);
        ctl_d.done = (ctl_d.state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_d;
    end

    assign sync_out = ctl_q.sync;
    assign done_out = ctl_q.done;
endmodule

// File: rtl/pps_sync_pulse_gen_chk.sv
module pps_sync_pulse_gen_chk (
    input logic clk,
    input logic rst,
    input logic arm_in,
    input logic sync_out,
    input logic done_out
);
    // R5: completion is never reported without SYNC
    p_done_implies_sync_r5: assert property (@(posedge clk) disable iff (rst)
        done_out |-> sync_out);

    // R5: done rises only after SYNC was already high
    p_done_after_sync_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_out) |-> $past(sync_out));

    // R6: a low trigger clears both outputs at the next edge
    p_release_clears_r6: assert property (@(posedge clk) disable iff (rst)
        !arm_in |=> (!sync_out && !done_out));

    // R2: SYNC can only rise when the trigger was high
    p_rise_needs_arm_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(arm_in));

    // R7: once high, SYNC holds while the trigger holds
    p_single_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_out && arm_in) |=> sync_out);

    // R1: reset leaves both outputs low
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (!sync_out && !done_out));
endmodule

bind pps_sync_pulse_gen pps_sync_pulse_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .arm_in   (arm_in),
    .sync_out (sync_out),
    .done_out (done_out)
);

// File: tb/tb_pps_sync_pulse_gen.sv
module tb_pps_sync_pulse_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pps_in = 1'b0;
    logic       arm_in = 1'b0;
    logic [7:0] extra_delay_in = 8'd0;
    logic       sync_out;
    logic       done_out;

    int n_chk = 0;
    int n_bad = 0;
    bit saw_high;

    localparam int NV = 5;
    localparam int VEC_D [NV] = '{0, 1, 3, 7, 255};
    localparam int VEC_T [NV] = '{2, 3, 5, 9, 257};

    always #2 clk = ~clk;

    pps_sync_pulse_gen dut (
        .clk            (clk),
        .rst            (rst),
        .pps_in         (pps_in),
        .arm_in         (arm_in),
        .extra_delay_in (extra_delay_in),
        .sync_out       (sync_out),
        .done_out       (done_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        chk("R1 reset sync", sync_out, 0);
        chk("R1 reset done", done_out, 0);
        rst = 1'b0;
        wait_n(3);

        // Latency table
        for (int i = 0; i < NV; i++) begin
            extra_delay_in = 8'(VEC_D[i]);
            arm_in = 1'b1;
            pps_in = 1'b0;
            wait_n(4);
            pps_in = 1'b1;
            for (int k = 1; k <= VEC_T[i] + 2; k++) begin
                @(negedge clk);
                if (k == VEC_T[i])     chk(i == 0 ? "R3 sync low before edge" : "R4 sync low before edge", sync_out, 0);
                if (k == VEC_T[i] + 1) chk(i == 0 ? "R3 sync at latency" : "R4 sync at latency", sync_out, 1);
                if (k == VEC_T[i] + 1) chk("R5 done lags sync", done_out, 0);
                if (k == VEC_T[i] + 2) chk("R5 done raised", done_out, 1);
            end
            wait_n(5);
            chk("R5 sync held", sync_out, 1);
            chk("R5 done held", done_out, 1);
            arm_in = 1'b0;
            pps_in = 1'b0;
            @(negedge clk);
            chk("R6 sync cleared", sync_out, 0);
            chk("R6 done cleared", done_out, 0);
            wait_n(3);
        end

        // R2: PPS edges while disarmed
        extra_delay_in = 8'd0;
        saw_high = 1'b0;
        for (int p = 0; p < 3; p++) begin
            pps_in = 1'b1;
            for (int k = 0; k < 6; k++) begin @(negedge clk); if (sync_out || done_out) saw_high = 1'b1; end
            pps_in = 1'b0;
            for (int k = 0; k < 6; k++) begin @(negedge clk); if (sync_out || done_out) saw_high = 1'b1; end
        end
        chk("R2 no output while disarmed", saw_high, 0);

        // R7: repeated PPS edges after completion
        arm_in = 1'b1;
        wait_n(4);
        pps_in = 1'b1;
        wait_n(6);
        chk("R7 first sync", sync_out, 1);
        saw_high = 1'b0;
        for (int p = 0; p < 2; p++) begin
            pps_in = 1'b0;
            for (int k = 0; k < 5; k++) begin @(negedge clk); if (!sync_out || !done_out) saw_high = 1'b1; end
            pps_in = 1'b1;
            for (int k = 0; k < 5; k++) begin @(negedge clk); if (!sync_out || !done_out) saw_high = 1'b1; end
        end
        chk("R7 no drop or re-fire", saw_high, 0);
        arm_in = 1'b0;
        pps_in = 1'b0;
        wait_n(4);

        // R9: level already high at arming
        pps_in = 1'b1;
        wait_n(5);
        arm_in = 1'b1;
        saw_high = 1'b0;
        for (int k = 0; k < 12; k++) begin @(negedge clk); if (sync_out) saw_high = 1'b1; end
        chk("R9 high level does not fire", saw_high, 0);
        pps_in = 1'b0;
        wait_n(4);
        pps_in = 1'b1;
        wait_n(2);
        chk("R9 low before fresh edge latency", sync_out, 0);
        @(negedge clk);
        chk("R9 fires on fresh edge", sync_out, 1);
        arm_in = 1'b0;
        pps_in = 1'b0;
        wait_n(4);

        // R8: trigger removed during delay
        extra_delay_in = 8'd20;
        arm_in = 1'b1;
        wait_n(4);
        pps_in = 1'b1;
        wait_n(6);
        arm_in = 1'b0;
        saw_high = 1'b0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (sync_out) saw_high = 1'b1; end
        chk("R8 aborted sequence silent", saw_high, 0);
        pps_in = 1'b0;
        wait_n(4);

        // R1: reset while done is high
        extra_delay_in = 8'd0;
        arm_in = 1'b1;
        wait_n(4);
        pps_in = 1'b1;
        wait_n(6);
        chk("R1 precondition done", done_out, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset sync", sync_out, 0);
        chk("R1 mid reset done", done_out, 0);
        rst = 1'b0;
        arm_in = 1'b0;
        pps_in = 1'b0;
        wait_n(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule